// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps time of day as whole seconds, nanoseconds and a hidden binary fraction of a nanosecond. On every reference clock tick it adds a programmable step, made of a whole-nanosecond part and a sub-nanosecond part. Fraction overflow carries into nanoseconds. Nanoseconds wrap at one billion and carry into seconds. The seconds and nanoseconds are driven continuously on a time bus, so timestamping and event logic can sample them.

Software reaches the block through a small register port with registered read data. It can load the seconds (high part first, then the low part, which commits the load) and the nanoseconds. It can read both back and program the two step parts. Both step registers come out of reset at zero, so the time stands still until software writes a nonzero step. For example, a 25 MHz reference needs a whole-nanosecond step of 40.

Top module: `tod_counter`

## Requirements
- R1: After reset, seconds, nanoseconds, fraction, both step registers, the staged high seconds, the seconds snapshot and the read data are all zero. While both step values are zero and no load occurs, the time does not change.
- R2: Each tick adds the sub-nanosecond step (register 4, wdata[15:0]) to the 16-bit fraction modulo 2^16. A carry out of the fraction adds one extra nanosecond in the same tick.
- R3: Each tick adds the nanosecond step (register 3, wdata[7:0]) and the fraction carry to the nanoseconds. If the sum reaches 1,000,000,000, one billion is subtracted and seconds rise by one in the same cycle. Nanoseconds always stay below one billion.
- R4: Seconds are 48 bits wide and wrap from 2^48-1 to 0.
- R5: A write to register 0 stages wdata[15:0] as seconds bits [47:32]. A write to register 1 sets seconds to {staged, wdata[31:0]}. In that cycle nanoseconds and fraction keep their values and do not advance.
- R6: A write to register 2 whose wdata[29:0] is below one billion loads the nanoseconds, clears the fraction and holds the seconds, with no advance that cycle. A write with wdata[29:0] of one billion or more is ignored, and the counter advances normally in that cycle.
- R7: A read strobe latches read data one cycle later. Register 1 returns seconds[31:0], register 2 returns the nanoseconds, register 3 returns the nanosecond step, register 4 returns the sub-nanosecond step, and register 0 returns the snapshot. All values are zero-extended, and addresses 5 to 7 read as 0. Read data holds when there is no read strobe. Writes to addresses 5 to 7 change nothing.
- R8: Reading register 1 captures seconds[47:32] into the snapshot that register 0 returns. A seconds carry after that read does not alter the snapshot.
- R9: The time bus shows the registered seconds and nanoseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| tod_sec | output | 48 | Current seconds |
| tod_ns | output | 30 | Current nanoseconds |

## Verification
A software load and the per-tick advance can fall in the same cycle, and so can a low-seconds read and a seconds carry. The bench provokes the first pair with directed loads made while a nonzero step is running, and with random writes mixed into free running. It judges them against a bench model in which the load wins and the advance is skipped. It provokes the second pair by reading the low seconds just before a nanosecond rollover. It then expects the high-seconds read to return the pre-carry value, even though the live seconds have already moved.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int SEC_W    = 48;
    localparam int NS_W     = 30;
    localparam int FRAC_W   = 16;
    localparam int INC_NS_W = 8;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int SEC_HI_W = SEC_W - DATA_W;
    localparam logic [NS_W-1:0] NS_PER_SEC = NS_W'(1_000_000_000);

    typedef enum logic [ADDR_W-1:0] {
        REG_SEC_HI  = 3'd0,
        REG_SEC_LO  = 3'd1,
        REG_NSEC    = 3'd2,
        REG_INC_NS  = 3'd3,
        REG_INC_SUB = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } tod_t;

    typedef struct packed {
        logic [INC_NS_W-1:0] ns;
        logic [FRAC_W-1:0]   sub;
    } tod_inc_t;
endpackage

// File: rtl/tod_step.sv
module tod_step
    import tod_pkg::*;
(
    input  tod_t     cur,
    input  tod_inc_t inc,
    output tod_t     nxt
);
    localparam int FRAC_X = FRAC_W + 1;
    localparam int NS_X   = NS_W + 1;

    logic [FRAC_X-1:0] frac_sum;
    logic [NS_X-1:0]   ns_sum;
    logic              wrap;

    always_comb begin
        frac_sum = {1'b0, cur.frac} + {1'b0, inc.sub};
        ns_sum   = {1'b0, cur.ns} + NS_X'(inc.ns) + NS_X'(frac_sum[FRAC_W]);
        wrap     = (ns_sum >= {1'b0, NS_PER_SEC});
        nxt.frac = frac_sum[FRAC_W-1:0];
        nxt.ns   = wrap ? NS_W'(ns_sum - {1'b0, NS_PER_SEC}) : ns_sum[NS_W-1:0];
        nxt.sec  = cur.sec + SEC_W'(wrap);
    end
endmodule

// File: rtl/tod_regfile.sv
module tod_regfile
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEC_W-1:0]  sec_now,
    input  logic [NS_W-1:0]   ns_now,
    output tod_inc_t          inc,
    output logic              sec_load,
    output logic [SEC_W-1:0]  sec_load_val,
    output logic              ns_load,
    output logic [NS_W-1:0]   ns_load_val,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        tod_inc_t              inc;
        logic [SEC_HI_W-1:0]   stage;
        logic [SEC_HI_W-1:0]   snap;
        logic [DATA_W-1:0]     rdata;
    } rf_t;

    rf_t      rf_d, rf_q;
    reg_sel_e sel;
    logic     ns_ok;

    always_comb begin
        sel          = reg_sel_e'(addr);
        rf_d         = rf_q;
        ns_ok        = (wdata[NS_W-1:0] < NS_PER_SEC);
        sec_load     = wr && (sel == REG_SEC_LO);
        sec_load_val = {rf_q.stage, wdata};
        ns_load      = wr && (sel == REG_NSEC) && ns_ok;
        ns_load_val  = wdata[NS_W-1:0];

        if (wr) begin
            case (sel)
                REG_SEC_HI:  rf_d.stage   = wdata[SEC_HI_W-1:0];
                REG_INC_NS:  rf_d.inc.ns  = wdata[INC_NS_W-1:0];
                REG_INC_SUB: rf_d.inc.sub = wdata[FRAC_W-1:0];
                default: ;
            endcase
        end

        if (rd) begin
            case (sel)
                REG_SEC_HI:  rf_d.rdata = DATA_W'(rf_q.snap);
                REG_SEC_LO: begin
                    rf_d.rdata = sec_now[DATA_W-1:0];
                    rf_d.snap  = sec_now[SEC_W-1:DATA_W];
                end
                REG_NSEC:    rf_d.rdata = DATA_W'(ns_now);
                REG_INC_NS:  rf_d.rdata = DATA_W'(rf_q.inc.ns);
                REG_INC_SUB: rf_d.rdata = DATA_W'(rf_q.inc.sub);
                default:     rf_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rf_q <= '0;
        else     rf_q <= rf_d;
    end

    assign inc   = rf_q.inc;
    assign rdata = rf_q.rdata;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata)); // R7
    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == REG_SEC_LO) |=> (rf_q.snap == $past(sec_now[SEC_W-1:DATA_W]))); // R8
endmodule

// File: rtl/tod_core.sv
module tod_core
    import tod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tod_inc_t         inc,
    input  logic             sec_load,
    input  logic [SEC_W-1:0] sec_load_val,
    input  logic             ns_load,
    input  logic [NS_W-1:0]  ns_load_val,
    output tod_t             tod
);
    tod_t tod_d, tod_q, stepped;

    tod_step u_step (
        .cur (tod_q),
        .inc (inc),
        .nxt (stepped)
    );

    always_comb begin
        tod_d = tod_q;
        if (sec_load) begin
            tod_d.sec = sec_load_val;
        end else if (ns_load) begin
            tod_d.ns   = ns_load_val;
            tod_d.frac = '0;
        end else begin
            tod_d = stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tod_q <= '0;
        else     tod_q <= tod_d;
    end

    assign tod = tod_q;

    AST_NS_BELOW_BILLION: assert property (@(posedge clk) disable iff (rst)
        tod_q.ns < NS_PER_SEC); // R3
    AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (rst)
        !(sec_load || ns_load) |=> ((tod_q.ns < $past(tod_q.ns)) == (tod_q.sec != $past(tod_q.sec)))); // R3
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        !(sec_load || ns_load) |=> (tod_q.sec == $past(tod_q.sec) || tod_q.sec == $past(tod_q.sec) + 1'b1)); // R4
    AST_SEC_LOAD: assert property (@(posedge clk) disable iff (rst)
        sec_load |=> (tod_q.sec == $past(sec_load_val) && $stable(tod_q.ns) && $stable(tod_q.frac))); // R5
    AST_NS_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ns_load && !sec_load) |=> (tod_q.ns == $past(ns_load_val) && tod_q.frac == '0 && $stable(tod_q.sec))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sec_load && !ns_load && inc.ns == '0 && inc.sub == '0) |=> $stable(tod_q)); // R1
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns
);
    tod_t             tod;
    tod_inc_t         inc;
    logic             sec_load, ns_load;
    logic [SEC_W-1:0] sec_load_val;
    logic [NS_W-1:0]  ns_load_val;

    tod_regfile u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr           (reg_wr),
        .rd           (reg_rd),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .sec_now      (tod.sec),
        .ns_now       (tod.ns),
        .inc          (inc),
        .sec_load     (sec_load),
        .sec_load_val (sec_load_val),
        .ns_load      (ns_load),
        .ns_load_val  (ns_load_val),
        .rdata        (reg_rdata)
    );

    tod_core u_core (
        .clk          (clk),
        .rst          (rst),
        .inc          (inc),
        .sec_load     (sec_load),
        .sec_load_val (sec_load_val),
        .ns_load      (ns_load),
        .ns_load_val  (ns_load_val),
        .tod          (tod)
    );

    assign tod_sec = tod.sec;
    assign tod_ns  = tod.ns;

    AST_BUS_RANGE: assert property (@(posedge clk) disable iff (rst)
        tod_ns < NS_PER_SEC); // R9
endmodule

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0, rd = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [47:0] sec;
    logic [29:0] ns;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    logic [47:0] m_sec;
    logic [29:0] m_ns;
    logic [15:0] m_frac, m_isub, m_stage, m_snap;
    logic [7:0]  m_ins;
    logic [31:0] m_rdata;

    localparam logic [29:0] BILLION = 30'd1_000_000_000;

    tod_counter u0 (
        .clk(clk), .rst(rst), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .tod_sec(sec), .tod_ns(ns)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] read_value(input logic [2:0] a);
        case (a)
            3'd0: return {16'h0, m_snap};
            3'd1: return m_sec[31:0];
            3'd2: return {2'b0, m_ns};
            3'd3: return {24'h0, m_ins};
            3'd4: return {16'h0, m_isub};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_edge(input logic w, input logic r, input logic [2:0] a, input logic [31:0] d);
        logic [16:0] fs;
        logic [30:0] nsum;
        logic        load;
        load = w && (a == 3'd1 || (a == 3'd2 && d[29:0] < BILLION));
        if (r) begin
            m_rdata = read_value(a);
            if (a == 3'd1) m_snap = m_sec[47:32];
        end
        if (!load) begin
            fs     = {1'b0, m_frac} + {1'b0, m_isub};
            nsum   = {1'b0, m_ns} + {23'b0, m_ins} + {30'b0, fs[16]};
            m_frac = fs[15:0];
            if (nsum >= {1'b0, BILLION}) begin
                m_ns  = 30'(nsum - {1'b0, BILLION});
                m_sec = m_sec + 48'd1;
            end else begin
                m_ns = nsum[29:0];
            end
        end
        if (w) begin
            case (a)
                3'd0: m_stage = d[15:0];
                3'd1: m_sec = {m_stage, d};
                3'd2: if (d[29:0] < BILLION) begin m_ns = d[29:0]; m_frac = '0; end
                3'd3: m_ins = d[7:0];
                3'd4: m_isub = d[15:0];
                default: ;
            endcase
        end
    endtask

    task automatic cyc(input string tag, input logic w, input logic r, input logic [2:0] a, input logic [31:0] d);
        wr = w; rd = r; addr = a; wdata = d;
        @(posedge clk);
        model_edge(w, r, a, d);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        chk(tag, "seconds", {16'h0, sec}, {16'h0, m_sec});
        chk(tag, "nanoseconds", {34'h0, ns}, {34'h0, m_ns});
        if (r) chk(tag, "read data", {32'h0, rdata}, {32'h0, m_rdata});
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'h1d5eed));
        m_sec = '0; m_ns = '0; m_frac = '0; m_isub = '0; m_stage = '0;
        m_snap = '0; m_ins = '0; m_rdata = '0;
        repeat (3) @(negedge clk);
        chk("R1", "reset seconds", {16'h0, sec}, 64'h0);
        chk("R1", "reset nanoseconds", {34'h0, ns}, 64'h0);
        chk("R1", "reset read data", {32'h0, rdata}, 64'h0);
        rst = 1'b0;
        idle("R1", 5);
        cyc("R1", 1'b0, 1'b1, 3'd3, 32'h0);
        cyc("R1", 1'b0, 1'b1, 3'd0, 32'h0);

        // R5 seconds load and R7/R8 readback
        cyc("R5", 1'b1, 1'b0, 3'd0, 32'h0000_00ab);
        cyc("R5", 1'b1, 1'b0, 3'd1, 32'h1234_5678);
        cyc("R7", 1'b0, 1'b1, 3'd1, 32'h0);
        cyc("R8", 1'b0, 1'b1, 3'd0, 32'h0);
        cyc("R7", 1'b0, 1'b1, 3'd7, 32'h0);
        idle("R7", 2);
        cyc("R7", 1'b1, 1'b0, 3'd6, 32'hffff_ffff);

        // R3 step of 40 ns and rollover
        cyc("R3", 1'b1, 1'b0, 3'd3, 32'h0000_0028);
        cyc("R7", 1'b0, 1'b1, 3'd3, 32'h0);
        idle("R3", 3);
        cyc("R6", 1'b1, 1'b0, 3'd2, 32'd999_999_900);
        idle("R3", 4);
        cyc("R6", 1'b1, 1'b0, 3'd2, 32'd1_000_000_000);
        cyc("R6", 1'b1, 1'b0, 3'd2, 32'hc000_0010);
        idle("R6", 2);

        // R4 seconds wrap
        cyc("R4", 1'b1, 1'b0, 3'd0, 32'h0000_ffff);
        cyc("R4", 1'b1, 1'b0, 3'd1, 32'hffff_ffff);
        cyc("R4", 1'b1, 1'b0, 3'd2, 32'd999_999_960);
        idle("R4", 3);

        // R8 snapshot across a carry
        cyc("R8", 1'b1, 1'b0, 3'd0, 32'h0000_0001);
        cyc("R8", 1'b1, 1'b0, 3'd1, 32'hffff_ffff);
        cyc("R8", 1'b1, 1'b0, 3'd2, 32'd999_999_960);
        cyc("R8", 1'b0, 1'b1, 3'd1, 32'h0);
        idle("R8", 2);
        cyc("R8", 1'b0, 1'b1, 3'd0, 32'h0);
        chk("R8", "snapshot before carry", {32'h0, rdata}, 64'h1);

        // R2 fraction carry
        cyc("R2", 1'b1, 1'b0, 3'd3, 32'h0);
        cyc("R2", 1'b1, 1'b0, 3'd4, 32'h0000_8000);
        cyc("R2", 1'b1, 1'b0, 3'd2, 32'd0);
        idle("R2", 6);
        chk("R2", "half-ns step after six ticks", {34'h0, ns}, 64'd3);
        cyc("R7", 1'b0, 1'b1, 3'd4, 32'h0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic        w, r;
            logic [2:0]  a;
            logic [31:0] d;
            w = ($urandom % 10) < 3;
            r = ($urandom % 10) < 3;
            a = 3'($urandom % 8);
            d = $urandom;
            if (a == 3'd2 && ($urandom % 2) == 0) d = 32'd999_998_000 + ($urandom % 4000);
            cyc("R9", w, r, a, d);
        end
        summary();
    end
endmodule